// File: doc/BRIEF.md
# 24-Hour Time-of-Day Counter with In-Place Setting

This block keeps the time of day as hours, minutes and seconds in 24-hour form. A divider counts `CLK_HZ` system-clock cycles for each second. The same divider also produces a half-second phase. Hours and minutes leave the block as packed BCD digit pairs, ready for a four-digit seven-segment decoder. Seconds leave it as a 6-bit binary value for a LED bank. A single enable, `show_o`, gates both displays.

An external key classifier drives `set_mode_i` while the user adjusts the time. It sends one-cycle `min_step_i` pulses for short presses and `hour_step_i` pulses, one per second held, for long presses. While set mode is active the displays blink, dark for the first half of every second and lit for the second half. Time keeps running whether or not set mode is active. The counters change only through the step requests.

Top module: `tod_clock`

## Requirements
- R1: After reset the time reads 00:00:00 and the blink phase is in its dark half.
- R2: Seconds advance by one every `CLK_HZ` clock cycles. The first advance takes effect on the `CLK_HZ`-th rising edge after reset is released.
- R3: Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0, so 23:59:59 is followed by 00:00:00.
- R4: `hours_bcd_o` and `minutes_bcd_o` hold the tens digit in bits [7:4] and the units digit in bits [3:0]. `seconds_o` is the plain binary second count, 0 to 59.
- R5: While `set_mode_i` is low, `show_o` is high.
- R6: While `set_mode_i` is high, `show_o` is low during the first `CLK_HZ/2` cycles of each second and high during the remaining `CLK_HZ/2` cycles.
- R7: A `min_step_i` pulse in set mode adds one minute and clears the seconds to 0. At minute 59 the minutes wrap to 00 and the hour advances by one.
- R8: An `hour_step_i` pulse in set mode adds one hour and leaves minutes and seconds unchanged. Hour 23 wraps to 00.
- R9: Step pulses have no effect while `set_mode_i` is low.
- R10: If both step pulses arrive in the same cycle, the hour step is dropped. Any accepted step cancels the one-second advance that falls in that same cycle.
- R11: In set mode, cycles without a step pulse keep counting seconds as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_mode_i | input | 1 | Set mode active |
| min_step_i | input | 1 | One-cycle request to add a minute |
| hour_step_i | input | 1 | One-cycle request to add an hour |
| hours_bcd_o | output | 8 | Hours, two BCD digits |
| minutes_bcd_o | output | 8 | Minutes, two BCD digits |
| seconds_o | output | 6 | Seconds, binary |
| show_o | output | 1 | Display enable, includes the blink |

## Verification
Two cases are the hardest to reach from the ports: a step pulse that lands on exactly the cycle of a second boundary, and the 23:59:59 day wrap. Waiting for the wrap in real time would take a full day of seconds. Instead, the bench uses set-mode step sequences to move the clock to 23:59. It then leaves set mode and runs past the midnight carry. The bench counts cycles since reset so that it can place step pulses on the exact edge where a second boundary falls.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned SEC_MAX  = 59;
  localparam int unsigned MIN_MAX  = 59;
  localparam int unsigned HOUR_MAX = 23;

  // tens in [7:4], units in [3:0]; v <= 63
  function automatic logic [7:0] bin2bcd(input logic [5:0] v);
    logic [5:0] t;
    logic [5:0] u;
    t = v / 6'd10;
    u = v - t * 6'd10;
    return {t[3:0], u[3:0]};
  endfunction
endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen #(
  parameter int unsigned CLK_HZ = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sec_tick_o,
  output logic phase_o
);
  localparam int unsigned HALF = CLK_HZ / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          half_tick;

  assign half_tick  = (cnt_q == CW'(HALF - 1));
  assign sec_tick_o = half_tick & phase_q;
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (half_tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_PHASE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick |=> phase_q != $past(phase_q)); // R6
  AST_SEC_STARTS_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !phase_q); // R6
endmodule

// File: rtl/tod_field.sv
module tod_field #(
  parameter int unsigned MAX = 59,
  localparam int unsigned W  = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         at_max_o
);
  logic [W-1:0] val_q;

  assign val_o    = val_q;
  assign at_max_o = (val_q == W'(MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (clr_i)    val_q <= '0;
    else if (inc_i)    val_q <= at_max_o ? '0 : val_q + 1'b1;
  end

  AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q <= W'(MAX)); // R3
  AST_FIELD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && at_max_o |=> val_q == '0); // R3
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_mode_i,
  input  logic       min_step_i,
  input  logic       hour_step_i,
  output logic [7:0] hours_bcd_o,
  output logic [7:0] minutes_bcd_o,
  output logic [5:0] seconds_o,
  output logic       show_o
);
  logic       sec_tick, phase;
  logic       do_min, do_hour, adv_sec;
  logic       sec_max, min_max, hr_max;
  logic       min_inc, hr_inc;
  logic [5:0] sec_val, min_val;
  logic [4:0] hr_val;

  tod_tick_gen #(.CLK_HZ(CLK_HZ)) i_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_o (sec_tick),
    .phase_o    (phase)
  );

  // steps only in set mode; minute wins over hour; a step eats the tick
  assign do_min  = set_mode_i & min_step_i;
  assign do_hour = set_mode_i & hour_step_i & ~min_step_i;
  assign adv_sec = sec_tick & ~do_min & ~do_hour;
  assign min_inc = do_min | (adv_sec & sec_max);
  assign hr_inc  = do_hour | (min_inc & min_max);

  tod_field #(.MAX(SEC_MAX)) i_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(do_min), .inc_i(adv_sec),
    .val_o(sec_val), .at_max_o(sec_max)
  );
  tod_field #(.MAX(MIN_MAX)) i_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .inc_i(min_inc),
    .val_o(min_val), .at_max_o(min_max)
  );
  tod_field #(.MAX(HOUR_MAX)) i_hr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .inc_i(hr_inc),
    .val_o(hr_val), .at_max_o(hr_max)
  );

  assign hours_bcd_o   = bin2bcd({1'b0, hr_val});
  assign minutes_bcd_o = bin2bcd(min_val);
  assign seconds_o     = sec_val;
  assign show_o        = ~set_mode_i | phase;

  AST_MIN_STEP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_i && min_step_i |=> seconds_o == 6'd0); // R7
  AST_HOUR_STEP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_i && hour_step_i && !min_step_i |=> $stable(min_val) && $stable(sec_val)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_mode_i && !sec_tick |=> $stable(sec_val) && $stable(min_val) && $stable(hr_val)); // R9
  AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hr_max && min_max && sec_max && adv_sec |=> hr_val == 5'd0 && min_val == 6'd0); // R3
endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;
  localparam int unsigned CLK_HZ = 4;
  localparam int unsigned HALF   = CLK_HZ / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_mode = 1'b0, min_step = 1'b0, hour_step = 1'b0;
  logic [7:0] hours_bcd, minutes_bcd;
  logic [5:0] seconds;
  logic       show;

  int checks = 0, errors = 0;
  int n = 0, h = 0, m = 0, s = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  tod_clock #(.CLK_HZ(CLK_HZ)) i_tod_clock (
    .clk_i(clk), .rst_ni(rst_n), .set_mode_i(set_mode),
    .min_step_i(min_step), .hour_step_i(hour_step),
    .hours_bcd_o(hours_bcd), .minutes_bcd_o(minutes_bcd),
    .seconds_o(seconds), .show_o(show)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  // R4: tens digit in [7:4], units in [3:0]
  task automatic compare_all(input string req);
    check(req, hours_bcd, ((h / 10) << 4) | (h % 10));
    check(req, minutes_bcd, ((m / 10) << 4) | (m % 10));
    check(req, seconds, s);
    if (set_mode) check("R6", show, ((n / HALF) % 2 == 1) ? 1 : 0);
    else          check("R5", show, 1);
  endtask

  // drives at negedge, one rising edge, model update, compare at negedge
  task automatic cyc(input logic st, input logic ms, input logic hs);
    bit tick;
    set_mode = st; min_step = ms; hour_step = hs;
    @(posedge clk);
    n++;
    tick = (n % CLK_HZ) == 0;
    if (st && ms) begin
      m++; s = 0;
      if (m == 60) begin m = 0; h = (h + 1) % 24; end
    end else if (st && hs) begin
      h = (h + 1) % 24;
    end else if (tick) begin
      s++;
      if (s == 60) begin
        s = 0; m++;
        if (m == 60) begin m = 0; h = (h + 1) % 24; end
      end
    end
    @(negedge clk);
    min_step = 1'b0; hour_step = 1'b0;
    compare_all(cur_req);
  endtask

  task automatic run(input logic st, input int cycles);
    for (int i = 0; i < cycles; i++) cyc(st, 1'b0, 1'b0);
  endtask

  // advance with set held until the next edge is a second boundary
  task automatic align_to_tick(input logic st);
    while (((n + 1) % CLK_HZ) != 0) cyc(st, 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", hours_bcd, 0); check("R1", minutes_bcd, 0);
    check("R1", seconds, 0);   check("R1", show, 1);
    rst_n = 1'b1;
    set_mode = 1'b1; #0;
    check("R1", show, 0);
    set_mode = 1'b0;

    // R2, R3: second cadence, minute carry, several minutes
    cur_req = "R2"; run(1'b0, CLK_HZ * 130);

    // R11: set mode without steps keeps counting; R6 blink
    cur_req = "R11"; run(1'b1, CLK_HZ * 3);

    // R9: steps outside set mode ignored
    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin cyc(1'b0, 1'b1, 1'b0); cyc(1'b0, 1'b0, 1'b1); end

    // R8: full hour sweep with wrap 23->0
    cur_req = "R8";
    for (int i = 0; i < 25; i++) begin cyc(1'b1, 1'b0, 1'b1); cyc(1'b1, 1'b0, 1'b0); end

    // R7: full minute sweep, wrap at 59 carries hour
    cur_req = "R7";
    for (int i = 0; i < 61; i++) begin cyc(1'b1, 1'b1, 1'b0); cyc(1'b1, 1'b0, 1'b0); end

    // R10: both steps at once, then steps on a second boundary
    cur_req = "R10";
    cyc(1'b1, 1'b1, 1'b1);
    run(1'b1, CLK_HZ * 2);
    align_to_tick(1'b1); cyc(1'b1, 1'b1, 1'b0);
    align_to_tick(1'b1); cyc(1'b1, 1'b0, 1'b1);
    align_to_tick(1'b1); cyc(1'b1, 1'b1, 1'b1);

    // R3: move to 23:59 by steps, then run through midnight
    cur_req = "R8";
    while (h != 23) cyc(1'b1, 1'b0, 1'b1);
    cur_req = "R7";
    while (m != 59) cyc(1'b1, 1'b1, 1'b0);
    cur_req = "R3";
    run(1'b0, CLK_HZ * 62);
    check("R3", hours_bcd, 0);

    // R8: hour step at 23 leaves minutes alone
    cur_req = "R8";
    while (h != 23) cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    check("R8", hours_bcd, 0);
    cur_req = "R5"; run(1'b0, CLK_HZ * 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule